// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block derives two audio clocks from a fast module clock. A master clock is divided down from the module clock, and a serial bit clock is divided down from the master clock. Both ratios come from small code fields that index fixed tables, so the block reaches ratios such as 6, 12 and 24 as well as powers of two. Every ratio other than one is even, and each output is high for the first half of its period and low for the second half, so the duty cycle is exactly 50%.

A third output marks the start of each audio frame. It is a one-cycle strobe on the module clock that occurs at a bit-clock rising edge once every `2*WORD_BITS` bit-clock periods. The strobe lets downstream serialisers align their word counters without counting bit-clock edges themselves.

A code change is picked up only when the running period of that output ends, so neither output ever shows a shortened pulse. Dropping the enable clears every counter at once.

Top module: `audio_clkgen`

## Requirements
- R1: Master-clock code values 0,1,2,3,4,5,6,7 give master periods of 1,2,4,6,8,12,16,24 module-clock cycles.
- R2: Bit-clock code values 0,1,2,3,4,5 give bit periods of 2,4,6,8,12,16 master-clock periods. The bit clock changes level only at a master-clock rising edge.
- R3: Bit-clock code values 6 and 7 hold the bit clock low and produce no frame strobes.
- R4: For every ratio of two or more, each output starts its period high. It stays high for exactly half the period and low for the other half.
- R5: While the enable is low, the master clock, bit clock and frame strobe are all low. The first enabled module-clock edge starts a new master period, a new bit period and a new frame.
- R6: A new code is taken only when the current period of that output ends. Before then, the output keeps the timing of the old code.
- R7: The frame strobe is high for exactly one module-clock cycle. It coincides with a bit-clock rising edge and repeats every `2*WORD_BITS` bit periods. The first bit period after a start is also the first period of a frame.
- R8: During reset all outputs are low, and the block behaves as if the enable had just been low.
- R9: At master ratio 1, the master clock output follows the module clock.
- R10: Master-clock code values 8 to 15 hold the master clock low, and the bit clock and frame logic stay cleared until a valid code is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_en_i | input | 1 | Master-clock enable |
| mclk_code_i | input | 4 | Master-clock divider code |
| bclk_code_i | input | 3 | Bit-clock divider code |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| frame_o | output | 1 | Frame-start strobe, one module-clock cycle wide |

## Verification
The assertions check several properties on every cycle:
- A divider changes level only when it is stepped.
- The ratio a divider is using changes only at a period boundary.
- A reserved bit-clock code keeps the bit clock low.
- The frame strobe lasts one cycle and lands on a high bit clock.
- Disabling clears all outputs.

Exact periods, the half-high/half-low split for each table entry, and the moment a changed code takes over can only be shown by the bench scenarios. The bench compares every output against a behavioural model on every cycle. It also measures the module-clock distance between frame strobes.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    localparam int MCODE_W = 4;
    localparam int BCODE_W = 3;
    localparam int RATIO_W = 5;

    // Master divider table; zero marks a reserved code
    function automatic logic [RATIO_W-1:0] master_ratio(input logic [MCODE_W-1:0] code);
        case (code)
            4'd0:    master_ratio = RATIO_W'(1);
            4'd1:    master_ratio = RATIO_W'(2);
            4'd2:    master_ratio = RATIO_W'(4);
            4'd3:    master_ratio = RATIO_W'(6);
            4'd4:    master_ratio = RATIO_W'(8);
            4'd5:    master_ratio = RATIO_W'(12);
            4'd6:    master_ratio = RATIO_W'(16);
            4'd7:    master_ratio = RATIO_W'(24);
            default: master_ratio = '0;
        endcase
    endfunction

    // Bit divider table, counted in master periods; zero marks a reserved code
    function automatic logic [RATIO_W-1:0] bit_ratio(input logic [BCODE_W-1:0] code);
        case (code)
            3'd0:    bit_ratio = RATIO_W'(2);
            3'd1:    bit_ratio = RATIO_W'(4);
            3'd2:    bit_ratio = RATIO_W'(6);
            3'd3:    bit_ratio = RATIO_W'(8);
            3'd4:    bit_ratio = RATIO_W'(12);
            3'd5:    bit_ratio = RATIO_W'(16);
            default: bit_ratio = '0;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
    import audio_clkgen_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1,
    parameter int CODE_W    = MCODE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               step_i,
    input  logic [CODE_W-1:0]  code_i,
    output logic               lvl_o,
    output logic               tick_o,
    output logic [RATIO_W-1:0] ratio_o
);

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] cnt;
        logic               lvl;
    } div_state_t;

    div_state_t         st_d, st_q;
    logic [RATIO_W-1:0] lut_ratio;
    logic               tick;

    generate
        if (IS_MASTER) begin : g_master
            assign lut_ratio = master_ratio(MCODE_W'(code_i));
        end else begin : g_bit
            assign lut_ratio = bit_ratio(BCODE_W'(code_i));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (st_q.cnt == '0) begin
                // Period boundary: the only place a new code is taken
                st_d.ratio = lut_ratio;
                if (lut_ratio != '0) begin
                    st_d.cnt = lut_ratio - 1'b1;
                    st_d.lvl = 1'b1;
                    tick     = 1'b1;
                end else begin
                    st_d.cnt = '0;
                    st_d.lvl = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
                st_d.lvl = (st_d.cnt >= (st_q.ratio >> 1));
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o   = st_q.lvl;
    assign tick_o  = tick;
    assign ratio_o = st_q.ratio;

    AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !step_i) |=> $stable(st_q.lvl)); // R2
    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && step_i && st_q.cnt != '0) |=> $stable(st_q.ratio)); // R6
    AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!st_q.lvl && st_q.cnt == '0)); // R5
    AST_RESERVED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ratio == '0) |-> !st_q.lvl); // R3

endmodule

// File: rtl/frame_strobe.sv
module frame_strobe #(
    parameter int FRAME_LEN = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic step_i,
    output logic pulse_o
);

    localparam int FW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    typedef struct packed {
        logic [FW-1:0] rem;
        logic          pulse;
    } frm_state_t;

    frm_state_t fr_d, fr_q;

    always_comb begin
        fr_d       = fr_q;
        fr_d.pulse = 1'b0;
        if (!run_i) begin
            fr_d = '0;
        end else if (step_i) begin
            fr_d.pulse = (fr_q.rem == '0);
            fr_d.rem   = (fr_q.rem == '0) ? FW'(FRAME_LEN - 1) : fr_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fr_q <= '0;
        else         fr_q <= fr_d;
    end

    assign pulse_o = fr_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fr_q.pulse |=> !fr_q.pulse); // R7
    AST_PULSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !fr_q.pulse); // R5

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int WORD_BITS = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               mclk_en_i,
    input  logic [MCODE_W-1:0] mclk_code_i,
    input  logic [BCODE_W-1:0] bclk_code_i,
    output logic               mclk_o,
    output logic               bclk_o,
    output logic               frame_o
);

    localparam int FRAME_LEN = 2 * WORD_BITS;

    logic               m_lvl, m_tick, b_lvl, b_tick, b_run;
    logic [RATIO_W-1:0] m_ratio, b_ratio;

    clkdiv_stage #(.IS_MASTER(1'b1), .CODE_W(MCODE_W)) u_mdiv (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (mclk_en_i),
        .step_i (1'b1),
        .code_i (mclk_code_i),
        .lvl_o  (m_lvl),
        .tick_o (m_tick),
        .ratio_o(m_ratio)
    );

    // Bit and frame logic run while the master clock is live or starting
    assign b_run = mclk_en_i && (m_tick || (m_ratio != '0));

    clkdiv_stage #(.IS_MASTER(1'b0), .CODE_W(BCODE_W)) u_bdiv (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (b_run),
        .step_i (m_tick),
        .code_i (bclk_code_i),
        .lvl_o  (b_lvl),
        .tick_o (b_tick),
        .ratio_o(b_ratio)
    );

    frame_strobe #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (b_run),
        .step_i (b_tick),
        .pulse_o(frame_o)
    );

    // Ratio 1 passes the module clock; the select changes only at a rising edge
    assign mclk_o = (m_ratio == RATIO_W'(1)) ? clk_i : m_lvl;
    assign bclk_o = b_lvl;

    AST_FRAME_ON_BCLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |-> bclk_o); // R7
    AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mclk_en_i |=> (!bclk_o && !frame_o && m_ratio == '0)); // R5
    AST_BCLK_RESERVED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (b_ratio == '0) |-> !bclk_o); // R3

endmodule

// File: tb/audio_clkgen_test.sv
module audio_clkgen_test;

    localparam int WORD_BITS = 16;
    localparam int FRAME     = 2 * WORD_BITS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] mcode = 4'd0;
    logic [2:0] bcode = 3'd0;
    logic       mclk_o, bclk_o, frame_o;

    always #5 clk = ~clk;

    audio_clkgen #(.WORD_BITS(WORD_BITS)) uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mclk_en_i  (en),
        .mclk_code_i(mcode),
        .bclk_code_i(bcode),
        .mclk_o     (mclk_o),
        .bclk_o     (bclk_o),
        .frame_o    (frame_o)
    );

    int    checks = 0;
    int    failures = 0;
    string tag = "R8";
    bit    done = 1'b0;

    // behavioural reference state
    int m_n = 0, m_age = 0, b_n = 0, b_age = 0, fbits = 0;
    bit e_mclk = 0, e_bclk = 0, e_frame = 0;
    int cyc = 0, last_frame = -1, gap_exp = 0;
    bit gap_on = 0;

    function automatic int m_table(int c);
        int v[8] = '{1, 2, 4, 6, 8, 12, 16, 24};
        return (c < 8) ? v[c] : 0;
    endfunction

    function automatic int b_table(int c);
        int v[6] = '{2, 4, 6, 8, 12, 16};
        return (c < 6) ? v[c] : 0;
    endfunction

    task automatic check(bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s cycle %0d actual=%0b expected=%0b", tag, what, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit mtick, btick, brun, prev_valid;
        mtick = 0; btick = 0;
        if (!rst_n || !en) begin
            m_n = 0; m_age = 0; b_n = 0; b_age = 0; fbits = 0;
            e_mclk = 0; e_bclk = 0; e_frame = 0;
        end else begin
            prev_valid = (m_n != 0);
            if (m_n == 0 || m_age == m_n - 1) begin
                m_n = m_table(int'(mcode)); m_age = 0;
                mtick = (m_n != 0);
            end else m_age++;
            e_mclk = (m_n == 0) ? 0 : (m_n == 1) ? 1 : (m_age < m_n / 2);
            brun = prev_valid || mtick;
            e_frame = 0;
            if (!brun) begin
                b_n = 0; b_age = 0; fbits = 0; e_bclk = 0;
            end else if (mtick) begin
                if (b_n == 0 || b_age == b_n - 1) begin
                    b_n = b_table(int'(bcode)); b_age = 0;
                    btick = (b_n != 0);
                end else b_age++;
                e_bclk = (b_n == 0) ? 0 : (b_age < b_n / 2);
                if (btick) begin
                    e_frame = (fbits % FRAME == 0);
                    fbits++;
                end
            end
        end
        #2;
        cyc++;
        check(mclk_o, e_mclk, "mclk");
        check(bclk_o, e_bclk, "bclk");
        check(frame_o, e_frame, "frame");
        if (gap_on && frame_o) begin
            if (last_frame >= 0) begin
                checks++;
                if (cyc - last_frame != gap_exp) begin
                    failures++;
                    $display("FAIL R7 frame gap actual=%0d expected=%0d", cyc - last_frame, gap_exp);
                end
            end
            last_frame = cyc;
        end
    end

    task automatic run(int n, string t);
        tag = t;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(5, "R8");                          // reset state
        @(negedge clk) rst_n = 1'b1;
        run(5, "R5");                          // enable still low
        en = 1'b1; mcode = 4'd0; bcode = 3'd0;
        run(200, "R9");                        // master ratio 1
        mcode = 4'd3; bcode = 3'd2;
        run(600, "R4");                        // ratio 6 / 6
        run(37, "R1");
        mcode = 4'd7; bcode = 3'd4;            // change mid-period
        run(1500, "R6");
        bcode = 3'd6;
        run(400, "R3");
        bcode = 3'd7;
        run(200, "R3");
        bcode = 3'd5;
        run(600, "R2");
        mcode = 4'd9;
        run(200, "R10");
        mcode = 4'd1; bcode = 3'd0;
        run(200, "R10");
        en = 1'b0;
        run(100, "R5");
        en = 1'b1; mcode = 4'd2; bcode = 3'd1;
        gap_exp = 4 * 4 * FRAME; gap_on = 1;
        run(1200, "R7");
        gap_on = 0;
        for (int c = 0; c < 8; c++) begin
            mcode = 4'(c);
            run(150, "R1");
        end
        for (int c = 0; c < 6; c++) begin
            bcode = 3'(c);
            run(400, "R2");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule